// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block computes a running cyclic redundancy check over data that is written to it a byte, a half-word or a word at a time. One of three generator polynomials is chosen at run time: two 16-bit ones (0x8005 and 0x1021) and one 32-bit one (0x04C11DB7). The running remainder can be set at any time from a programmable seed. The engine consumes one byte per clock cycle and raises a busy flag while bytes are still pending.

The input path can reflect the bits of each byte, reverse the order in which the bytes of a write are consumed, and invert each byte. The output path can reflect the whole checksum, swap its bytes and invert it. These transforms are independent, so the engine covers the common reflected and non-reflected CRC variants without any software pre- or post-processing. The checksum is always read from the output port. Its width follows the selected polynomial.

Top module: `crc_unit`

## Requirements
- R1: `poly_sel` picks the generator: 0 selects 0x8005 (16-bit), 1 selects 0x1021 (16-bit), and 2 or 3 select 0x04C11DB7 (32-bit). Each byte is folded in most significant bit first into a non-reflected shift register.
- R2: A pulse on `seed_we` replaces the running remainder at the next clock edge and discards any bytes still pending. In 16-bit modes only `seed_val[15:0]` is kept.
- R3: `wr_size` 0 takes `wr_data[7:0]`, 1 takes `wr_data[15:0]`, and 2 or 3 take all 32 bits. With no byte reversal, the least significant byte is consumed first.
- R4: An accepted write raises `busy` from the next cycle for exactly 1, 2 or 4 cycles (byte, half-word, word). One byte is folded per cycle. `busy` is low after reset, and the remainder resets to zero.
- R5: A write presented while `busy` is high is ignored and leaves the checksum unchanged.
- R6: With `in_byterev`, the valid bytes of a write are consumed most significant byte first.
- R7: With `in_bitrev`, the bit order inside every input byte is reflected before folding.
- R8: With `in_invert`, every input byte is complemented before folding.
- R9: With `out_bitrev`, the checksum is reflected over its full width (16 or 32 bits).
- R10: With `out_byterev`, the byte order of the checksum is reversed within its width.
- R11: With `out_invert`, the checksum is complemented within its width.
- R12: In the 16-bit modes, `crc_out[31:16]` is always zero.
- R13: A seed load and a write in the same idle cycle both take effect: the write's bytes are folded starting from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| poly_sel | input | 2 | Polynomial select (R1 encoding) |
| seed_we | input | 1 | Load seed into the running remainder |
| seed_val | input | 32 | Seed value |
| wr_en | input | 1 | Data write strobe |
| wr_size | input | 2 | Write size: 0 byte, 1 half-word, 2/3 word |
| wr_data | input | 32 | Write data |
| in_bitrev | input | 1 | Reflect bits within each input byte |
| in_byterev | input | 1 | Consume bytes of a write most significant first |
| in_invert | input | 1 | Complement each input byte |
| out_bitrev | input | 1 | Reflect the checksum over its width |
| out_byterev | input | 1 | Reverse checksum byte order |
| out_invert | input | 1 | Complement the checksum |
| busy | output | 1 | Bytes still pending |
| crc_out | output | 32 | Transformed checksum, upper half zero in 16-bit modes |

## Verification
A seed load can coincide with a data write, and a seed load can also arrive while bytes are still being folded. The bench drives `seed_we` and `wr_en` in the same idle cycle and expects the byte to be folded from the new seed. It also loads a seed one cycle into a word write and expects `busy` to drop at once, with the checksum equal to the seed. Both results are compared against a bit-serial reference model kept in the bench.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = CRC_W / 2;
    localparam int LANES  = CRC_W / BYTE_W;
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        SEL_ARC16  = 2'd0,
        SEL_CCITT  = 2'd1,
        SEL_ETH32  = 2'd2,
        SEL_ETH32B = 2'd3
    } poly_sel_e;

    localparam logic [CRC_W-1:0] POLY_ARC16 = 32'h0000_8005;
    localparam logic [CRC_W-1:0] POLY_CCITT = 32'h0000_1021;
    localparam logic [CRC_W-1:0] POLY_ETH32 = 32'h04C1_1DB7;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] queue;
        logic [CNT_W-1:0] left;
    } crc_state_t;

endpackage

// File: rtl/crc_in_fmt.sv
module crc_in_fmt
    import crc_unit_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NL = LANES,
    parameter int CW = CNT_W
) (
    input  logic [NL*BW-1:0] data_in,
    input  logic [1:0]       size,
    input  logic             bitrev,
    input  logic             byterev,
    input  logic             invert,
    output logic [NL*BW-1:0] queue_out,
    output logic [CW-1:0]    count_out
);

    logic [CW-1:0] n_bytes;

    always_comb begin
        case (size)
            2'd0:    n_bytes = CW'(1);
            2'd1:    n_bytes = CW'(2);
            default: n_bytes = CW'(NL);
        endcase
    end

    assign count_out = n_bytes;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [BW-1:0] picked;
        logic [BW-1:0] reflected;
        logic [BW-1:0] shaped;

        always_comb begin
            picked = '0;
            for (int s = 0; s < NL; s++) begin
                if (i < int'(n_bytes)) begin
                    if (byterev) begin
                        if (s == int'(n_bytes) - 1 - i) picked = data_in[s*BW +: BW];
                    end else begin
                        if (s == i) picked = data_in[s*BW +: BW];
                    end
                end
            end
        end

        always_comb begin
            reflected = picked;
            if (bitrev) begin
                for (int b = 0; b < BW; b++) reflected[b] = picked[BW-1-b];
            end
        end

        assign shaped = invert ? ~reflected : reflected;
        assign queue_out[i*BW +: BW] = shaped;
    end

endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_unit_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0]  crc_in,
    input  logic [BW-1:0] data_byte,
    input  logic [1:0]    poly_sel,
    output logic [W-1:0]  crc_next
);

    localparam int HW = W / 2;

    logic          wide;
    logic [W-1:0]  poly;
    logic [W-1:0]  acc;
    logic          fb;

    assign wide = poly_sel[1];

    always_comb begin
        case (poly_sel)
            SEL_ARC16: poly = W'(POLY_ARC16);
            SEL_CCITT: poly = W'(POLY_CCITT);
            default:   poly = W'(POLY_ETH32);
        endcase
    end

    always_comb begin
        if (wide) begin
            acc = crc_in ^ {data_byte, {(W-BW){1'b0}}};
        end else begin
            acc = {{HW{1'b0}}, crc_in[HW-1:0] ^ {data_byte, {(HW-BW){1'b0}}}};
        end
        fb = 1'b0;
        for (int k = 0; k < BW; k++) begin
            fb  = wide ? acc[W-1] : acc[HW-1];
            acc = acc << 1;
            if (!wide) acc[W-1:HW] = '0;
            if (fb) acc = acc ^ poly;
        end
        crc_next = acc;
    end

endmodule

// File: rtl/crc_out_fmt.sv
module crc_out_fmt
    import crc_unit_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int BW = BYTE_W
) (
    input  logic [W-1:0] crc_in,
    input  logic         wide,
    input  logic         bitrev,
    input  logic         byterev,
    input  logic         invert,
    output logic [W-1:0] crc_res
);

    logic [1:0][W-1:0] variant;

    for (genvar g = 0; g < 2; g++) begin : g_width
        localparam int VW = (g == 0) ? W / 2 : W;
        localparam int NB = VW / BW;

        logic [VW-1:0] src;
        logic [VW-1:0] t_bits;
        logic [VW-1:0] t_bytes;
        logic [VW-1:0] t_final;

        assign src = crc_in[VW-1:0];

        always_comb begin
            t_bits = src;
            if (bitrev) begin
                for (int k = 0; k < VW; k++) t_bits[k] = src[VW-1-k];
            end
        end

        always_comb begin
            t_bytes = t_bits;
            if (byterev) begin
                for (int k = 0; k < NB; k++) t_bytes[k*BW +: BW] = t_bits[(NB-1-k)*BW +: BW];
            end
        end

        assign t_final    = invert ? ~t_bytes : t_bytes;
        assign variant[g] = W'(t_final);
    end

    assign crc_res = variant[wide];

endmodule

// File: rtl/crc_unit.sv
module crc_unit
    import crc_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        poly_sel,
    input  logic              seed_we,
    input  logic [CRC_W-1:0]  seed_val,
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic [CRC_W-1:0]  wr_data,
    input  logic              in_bitrev,
    input  logic              in_byterev,
    input  logic              in_invert,
    input  logic              out_bitrev,
    input  logic              out_byterev,
    input  logic              out_invert,
    output logic              busy,
    output logic [CRC_W-1:0]  crc_out
);

    crc_state_t       state_q;
    crc_state_t       state_d;
    logic             wide;
    logic             idle;
    logic [CRC_W-1:0] fmt_queue;
    logic [CNT_W-1:0] fmt_count;
    logic [CRC_W-1:0] step_crc;

    assign wide = poly_sel[1];
    assign idle = (state_q.left == '0);

    crc_in_fmt #(.BW(BYTE_W), .NL(LANES), .CW(CNT_W)) in_fmt_i (
        .data_in   (wr_data),
        .size      (wr_size),
        .bitrev    (in_bitrev),
        .byterev   (in_byterev),
        .invert    (in_invert),
        .queue_out (fmt_queue),
        .count_out (fmt_count)
    );

    crc_byte_step #(.W(CRC_W), .BW(BYTE_W)) step_i (
        .crc_in    (state_q.crc),
        .data_byte (state_q.queue[BYTE_W-1:0]),
        .poly_sel  (poly_sel),
        .crc_next  (step_crc)
    );

    crc_out_fmt #(.W(CRC_W), .BW(BYTE_W)) out_fmt_i (
        .crc_in  (state_q.crc),
        .wide    (wide),
        .bitrev  (out_bitrev),
        .byterev (out_byterev),
        .invert  (out_invert),
        .crc_res (crc_out)
    );

    always_comb begin
        state_d = state_q;
        if (!idle) begin
            state_d.crc   = step_crc;
            state_d.queue = state_q.queue >> BYTE_W;
            state_d.left  = state_q.left - CNT_W'(1);
        end
        if (seed_we) begin
            state_d.crc   = wide ? seed_val : {{HALF_W{1'b0}}, seed_val[HALF_W-1:0]};
            state_d.queue = '0;
            state_d.left  = '0;
        end
        if (wr_en && idle) begin
            state_d.queue = fmt_queue;
            state_d.left  = fmt_count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy = !idle;

endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  poly_sel,
    input logic        seed_we,
    input logic [31:0] seed_val,
    input logic        wr_en,
    input logic [1:0]  wr_size,
    input logic        out_bitrev,
    input logic        out_byterev,
    input logic        out_invert,
    input logic        busy,
    input logic [31:0] crc_out
);

    AST_WRITE_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> busy); // R4

    AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_size == 2'd0) |=> busy ##1 !busy); // R4

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !poly_sel[1] |-> (crc_out[31:16] == 16'h0000)); // R12

    AST_SEED_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && poly_sel == 2'd2 && !out_bitrev && !out_byterev && !out_invert)
        |=> (poly_sel != 2'd2 || out_bitrev || out_byterev || out_invert
             || crc_out == $past(seed_val))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !seed_we) ##1 ($stable(poly_sel) && $stable({out_bitrev, out_byterev, out_invert}))
        |-> $stable(crc_out)); // R5

endmodule

bind crc_unit crc_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .poly_sel    (poly_sel),
    .seed_we     (seed_we),
    .seed_val    (seed_val),
    .wr_en       (wr_en),
    .wr_size     (wr_size),
    .out_bitrev  (out_bitrev),
    .out_byterev (out_byterev),
    .out_invert  (out_invert),
    .busy        (busy),
    .crc_out     (crc_out)
);

// File: tb/crc_unit_tb_top.sv
module crc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  poly_sel = 2'd0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_val = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic [31:0] wr_data = '0;
    logic        in_bitrev = 1'b0, in_byterev = 1'b0, in_invert = 1'b0;
    logic        out_bitrev = 1'b0, out_byterev = 1'b0, out_invert = 1'b0;
    logic        busy;
    logic [31:0] crc_out;

    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [31:0] ref_crc = '0;
    logic [7:0]  msg [0:8];

    always #10 clk = ~clk;

    crc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .seed_we(seed_we), .seed_val(seed_val),
        .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
        .in_bitrev(in_bitrev), .in_byterev(in_byterev), .in_invert(in_invert),
        .out_bitrev(out_bitrev), .out_byterev(out_byterev), .out_invert(out_invert),
        .busy(busy), .crc_out(crc_out)
    );

    function automatic logic [31:0] model_step(logic [31:0] c, logic [7:0] b, logic [1:0] sel);
        int          w;
        logic [31:0] p;
        logic        fb;
        w = sel[1] ? 32 : 16;
        p = (sel == 2'd0) ? 32'h8005 : (sel == 2'd1) ? 32'h1021 : 32'h04C11DB7;
        for (int j = 7; j >= 0; j--) begin
            fb = c[w-1] ^ b[j];
            c  = c << 1;
            if (w == 16) c[31:16] = '0;
            if (fb) c = c ^ p;
        end
        return c;
    endfunction

    function automatic logic [31:0] model_out(logic [31:0] c, logic [1:0] sel);
        int          w;
        logic [31:0] m, r;
        w = sel[1] ? 32 : 16;
        m = sel[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        r = c & m;
        if (out_bitrev) begin
            logic [31:0] t;
            t = '0;
            for (int k = 0; k < w; k++) t[k] = r[w-1-k];
            r = t;
        end
        if (out_byterev) begin
            if (w == 16) r = {16'h0, r[7:0], r[15:8]};
            else         r = {r[7:0], r[15:8], r[23:16], r[31:24]};
        end
        if (out_invert) r = ~r & m;
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [31:0] d, logic [1:0] sz);
        int         n;
        logic [7:0] b;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = in_byterev ? n - 1 - k : k;
            b = d[idx*8 +: 8];
            if (in_bitrev) b = {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
            if (in_invert) b = ~b;
            ref_crc = model_step(ref_crc, b, poly_sel);
        end
    endtask

    // drive one write at a negedge, then count busy cycles (R4)
    task automatic send(logic [31:0] d, logic [1:0] sz);
        int n, cnt;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        model_write(d, sz);
        wr_en = 1'b1; wr_data = d; wr_size = sz;
        @(negedge clk);
        wr_en = 1'b0;
        cnt = 0;
        while (busy && cnt < 10) begin
            cnt++;
            @(negedge clk);
        end
        check("R4 busy cycles", 32'(cnt), 32'(n));
    endtask

    task automatic load_seed(logic [31:0] v);
        seed_we = 1'b1; seed_val = v;
        @(negedge clk);
        seed_we = 1'b0;
        ref_crc = poly_sel[1] ? v : {16'h0, v[15:0]};
    endtask

    task automatic clear_modes();
        in_bitrev = 0; in_byterev = 0; in_invert = 0;
        out_bitrev = 0; out_byterev = 0; out_invert = 0;
    endtask

    task automatic t_reset();
        check("R4 reset busy", 32'(busy), 32'd0);
        check("R4 reset crc", crc_out, 32'd0);
    endtask

    task automatic t_arc16_known();
        clear_modes(); poly_sel = 2'd0; load_seed(32'h0);
        for (int i = 0; i < 9; i++) send({24'h0, msg[i]}, 2'd0);
        check("R1 crc16 0x8005 check value", crc_out, 32'h0000_FEE8);
    endtask

    task automatic t_ccitt_known();
        clear_modes(); poly_sel = 2'd1; load_seed(32'hFFFF_FFFF);
        for (int i = 0; i < 9; i++) send({24'h0, msg[i]}, 2'd0);
        check("R1 R2 ccitt check value", crc_out, 32'h0000_29B1);
    endtask

    task automatic t_eth_msb();
        clear_modes(); poly_sel = 2'd2; in_byterev = 1; load_seed(32'hFFFF_FFFF);
        send(32'h3132_3334, 2'd2);
        send(32'h3536_3738, 2'd2);
        send(32'h0000_0039, 2'd0);
        check("R6 R3 word byte order", crc_out, 32'h0376_E6E7);
    endtask

    task automatic t_eth_reflected();
        clear_modes(); poly_sel = 2'd2; in_bitrev = 1; out_bitrev = 1; out_invert = 1;
        load_seed(32'hFFFF_FFFF);
        send(32'h3433_3231, 2'd2);
        send(32'h3837_3635, 2'd2);
        send(32'h0000_0039, 2'd0);
        check("R7 R9 R11 reflected crc32", crc_out, 32'hCBF4_3926);
    endtask

    task automatic t_halfwords();
        clear_modes(); poly_sel = 2'd1; load_seed(32'h1D0F);
        send(32'hDEAD_A55A, 2'd1);
        in_byterev = 1;
        send(32'h0000_1234, 2'd1);
        check("R3 R6 half-word writes", crc_out, model_out(ref_crc, poly_sel));
    endtask

    task automatic t_invert_byteswap();
        clear_modes(); poly_sel = 2'd2; in_invert = 1; out_byterev = 1;
        load_seed(32'h1234_5678);
        send(32'hCAFE_F00D, 2'd2);
        send(32'h0000_00A7, 2'd0);
        check("R8 R10 crc32 transforms", crc_out, model_out(ref_crc, poly_sel));
        poly_sel = 2'd0; load_seed(32'h0000_BEEF);
        send(32'h0000_5A3C, 2'd1);
        check("R10 crc16 byte swap", crc_out, model_out(ref_crc, poly_sel));
    endtask

    task automatic t_busy_ignore();
        int cnt;
        clear_modes(); poly_sel = 2'd0; load_seed(32'h0);
        model_write(32'h0102_0304, 2'd2);
        wr_en = 1; wr_data = 32'h0102_0304; wr_size = 2'd2;
        @(negedge clk);
        wr_data = 32'hFFFF_FFFF; wr_size = 2'd2;   // still asserted while busy
        @(negedge clk);
        wr_en = 0;
        cnt = 1;
        while (busy && cnt < 10) begin
            cnt++;
            @(negedge clk);
        end
        check("R5 busy length unchanged", 32'(cnt), 32'd4);
        check("R5 ignored write", crc_out, model_out(ref_crc, poly_sel));
    endtask

    task automatic t_seed_flush();
        clear_modes(); poly_sel = 2'd2; load_seed(32'h0);
        wr_en = 1; wr_data = 32'h1111_2222; wr_size = 2'd2;
        @(negedge clk);
        wr_en = 0;
        load_seed(32'hA5A5_0F0F);
        check("R2 flush busy", 32'(busy), 32'd0);
        check("R2 seed replaces", crc_out, 32'hA5A5_0F0F);
    endtask

    task automatic t_seed_and_write();
        int cnt;
        clear_modes(); poly_sel = 2'd1; load_seed(32'h0);
        ref_crc = 32'h0000_4C21;
        model_write(32'h0000_00E3, 2'd0);
        seed_we = 1; seed_val = 32'h7777_4C21;
        wr_en = 1; wr_data = 32'h0000_00E3; wr_size = 2'd0;
        @(negedge clk);
        seed_we = 0; wr_en = 0;
        cnt = 0;
        while (busy && cnt < 10) begin
            cnt++;
            @(negedge clk);
        end
        check("R13 busy one cycle", 32'(cnt), 32'd1);
        check("R13 seed then byte", crc_out, model_out(ref_crc, poly_sel));
    endtask

    task automatic t_upper_zero();
        clear_modes(); poly_sel = 2'd2; load_seed(32'hFFFF_FFFF);
        poly_sel = 2'd0; out_invert = 1; load_seed(32'hFFFF_1234);
        check("R12 upper half zero", crc_out, 32'h0000_EDCB);
        send(32'h0000_0055, 2'd0);
        check("R12 R11 after byte", crc_out, model_out(ref_crc, poly_sel));
    endtask

    task automatic t_sel3();
        clear_modes(); poly_sel = 2'd3; load_seed(32'h0BAD_F00D);
        send(32'h0000_00C3, 2'd0);
        check("R1 select 3 is 32-bit", crc_out, model_out(ref_crc, 2'd2));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        msg[0] = 8'h31; msg[1] = 8'h32; msg[2] = 8'h33; msg[3] = 8'h34; msg[4] = 8'h35;
        msg[5] = 8'h36; msg[6] = 8'h37; msg[7] = 8'h38; msg[8] = 8'h39;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_arc16_known();
        t_ccitt_known();
        t_eth_msb();
        t_eth_reflected();
        t_halfwords();
        t_invert_byteswap();
        t_busy_ignore();
        t_seed_flush();
        t_seed_and_write();
        t_upper_zero();
        t_sel3();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule